// File: doc/BRIEF.md
# Four-Channel Shared-Buffer FIFO DMA Controller

This block moves bytes between up to four slow byte-wide peripherals and one shared byte buffer. Each channel carves its own circular region out of that buffer with a base register and a size register. Once enabled, a channel either collects bytes from its device into its region (receive) or feeds the bytes queued in its region to the device (send), paced by the device's request line. Only one byte moves per clock across all channels, and the channels take turns.

Software sees each channel through a 32-bit register window. Through it, software sets up the channel, watches the byte count and the interrupt state, and pushes or pops bytes through a data port. A popped byte is repeated in all four byte lanes of the returned word, so a byte load at any lane offset sees it. A single interrupt line combines the enabled status bits of all channels.

Each channel runs a four-state machine. CH_OFF is the disabled state. CH_RECV handles device-to-buffer transfers. CH_SEND handles buffer-to-device transfers. CH_DRAINED is a send channel whose queue has emptied. The transitions are:
- A mode write with the enable bit clear moves any state to CH_OFF.
- A mode write with enable set moves any state to CH_RECV or CH_SEND, depending on the direction bit.
- CH_SEND moves to CH_DRAINED when it sends the byte that brings the count to zero.
- CH_DRAINED holds until the next mode write.

Top module: `quad_fifo_dma`

## Requirements
- R1: After reset, every channel's size, base, mode, interrupt control, interrupt status, count and both positions are zero, and `irq` is low.
- R2: Byte address bits 17:16 pick the channel, and bits 15:8 must be zero. Word offsets within a window are: 0x00 size, 0x04 base, 0x0C mode, 0x18 interrupt control, 0x1C masked status, 0x30 count and 0x34 data port. A write to one channel leaves the other channels' registers unchanged.
- R3: A data-port write stores bits 7:0 at buffer address base+write position, adds one to the count, and advances the write position. Any position that is equal to or greater than size returns to 0 on advance, so a region holds size+1 bytes.
- R4: A data-port read returns the byte at base+read position, repeated in all four byte lanes, and advances the read position. It subtracts one from a nonzero count. If the count reaches zero, it clears the status.
- R5: In the mode register, bit 0 enables the channel and bit 1 selects the direction (1 = send, 0 = receive). While a channel is disabled, its request line produces no strobe and no change in the count.
- R6: A receive channel with its request line high may be granted a cycle. In a granted cycle it pulses `dev_rd` once, stores that cycle's device byte at base+write position, adds one to the count, advances the write position and sets the status.
- R7: A send channel with its request line high and a nonzero count may be granted a cycle. In a granted cycle it pulses `dev_wr` with the byte at base+read position, subtracts one from the count and advances the read position. Sending the last byte sets the status and enters CH_DRAINED, where no bytes are sent until the mode is written again.
- R8: Writing interrupt control clears the channel's status. Reading status returns the status ANDed with control bit 0. If a status-setting transfer falls in the same cycle as this write, the status stays set.
- R9: `irq` is the OR over all channels of status AND control bit 0.
- R10: At most one transfer happens per clock. When several channels request, grants rotate round-robin, starting after the last channel served.
- R11: In a cycle with a data-port access, no device strobe fires. The waiting transfer happens in a later cycle, and every byte is counted exactly once.
- R12: Writes to the count and status offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 18 | Byte address: channel in 17:16, offset in 7:0 |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, registered, valid the cycle after the read |
| dev_drq | input | NCH | Per-channel device request |
| dev_rd | output | NCH | Per-channel strobe: device byte taken this cycle |
| dev_rdata | input | NCH*8 | Per-channel device byte, channel i in bits 8i+7:8i |
| dev_wr | output | NCH | Per-channel strobe: byte offered on dev_wdata |
| dev_wdata | output | 8 | Byte to the device being served |
| irq | output | 1 | Combined interrupt |

## Verification
A data-port access and a DMA transfer both want the single buffer port, so the two can fall in the same cycle. The bench holds a receive channel's request high for three cycles and puts a data-port push to the same channel in the middle cycle. It then expects two device strobes, a count that rose by three, and the order device byte, pushed byte, device byte when the bytes are popped. A send channel that empties while its request stays high is also pushed a byte. It must stay silent in CH_DRAINED until the mode is rewritten.

// File: rtl/qfd_pkg.sv
`timescale 1ns/1ps
package qfd_pkg;
    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_RECV    = 2'd1,
        CH_SEND    = 2'd2,
        CH_DRAINED = 2'd3
    } ch_state_e;

    localparam logic [7:0] OFF_SIZE  = 8'h00;
    localparam logic [7:0] OFF_BASE  = 8'h04;
    localparam logic [7:0] OFF_MODE  = 8'h0C;
    localparam logic [7:0] OFF_ICTL  = 8'h18;
    localparam logic [7:0] OFF_ISTAT = 8'h1C;
    localparam logic [7:0] OFF_COUNT = 8'h30;
    localparam logic [7:0] OFF_DATA  = 8'h34;

    localparam int MODE_EN_BIT  = 0;
    localparam int MODE_DIR_BIT = 1;
endpackage

// File: rtl/qfd_buffer_ram.sv
`timescale 1ns/1ps
module qfd_buffer_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/qfd_rr_arbiter.sv
`timescale 1ns/1ps
module qfd_rr_arbiter #(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (!any && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
                any      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (any && advance) begin
            ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

    // R10
    gnt_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R10
    gnt_requested_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/qfd_channel.sv
`timescale 1ns/1ps
module qfd_channel import qfd_pkg::*; #(
    parameter int RAM_AW = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_size,
    input  logic              wr_base,
    input  logic              wr_mode,
    input  logic              wr_ictl,
    input  logic              push,
    input  logic              pop,
    input  logic [31:0]       wval,
    input  logic              drq,
    input  logic              gnt,
    output logic              want,
    output logic              is_send,
    output logic [RAM_AW-1:0] waddr,
    output logic [RAM_AW-1:0] raddr,
    output logic [RAM_AW-1:0] size_q,
    output logic [RAM_AW-1:0] base_q,
    output logic [1:0]        mode_q,
    output logic              ictl_q,
    output logic              istat_q,
    output logic [CNT_W-1:0]  cnt_q
);
    ch_state_e         st_q, st_d;
    logic [RAM_AW-1:0] wpos_q, rpos_q;
    logic              xfer_in, xfer_out, last_out;
    logic              set_ev, clr_ev;
    logic              unused_wval;

    assign unused_wval = ^wval;

    function automatic logic [RAM_AW-1:0] step(input logic [RAM_AW-1:0] p,
                                               input logic [RAM_AW-1:0] lim);
        return (p >= lim) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= CH_OFF;
        else     st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            if (!wval[MODE_EN_BIT])      st_d = CH_OFF;
            else if (wval[MODE_DIR_BIT]) st_d = CH_SEND;
            else                         st_d = CH_RECV;
        end else begin
            unique case (st_q)
                CH_OFF:     st_d = CH_OFF;
                CH_RECV:    st_d = CH_RECV;
                CH_SEND:    st_d = last_out ? CH_DRAINED : CH_SEND;
                CH_DRAINED: st_d = CH_DRAINED;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        want     = 1'b0;
        is_send  = 1'b0;
        unique case (st_q)
            CH_OFF:     want = 1'b0;
            CH_RECV:    want = drq;
            CH_SEND:    begin
                            is_send = 1'b1;
                            want    = drq && (cnt_q != '0);
                        end
            CH_DRAINED: want = 1'b0;
        endcase
        xfer_in  = gnt && (st_q == CH_RECV);
        xfer_out = gnt && (st_q == CH_SEND);
        last_out = xfer_out && (cnt_q == CNT_W'(1));
        set_ev   = xfer_in || last_out;
        clr_ev   = wr_ictl || (pop && cnt_q == CNT_W'(1));
    end

    assign waddr = base_q + wpos_q;
    assign raddr = base_q + rpos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q  <= '0;
            base_q  <= '0;
            mode_q  <= '0;
            ictl_q  <= 1'b0;
            istat_q <= 1'b0;
            cnt_q   <= '0;
            wpos_q  <= '0;
            rpos_q  <= '0;
        end else begin
            if (wr_size) size_q <= wval[RAM_AW-1:0];
            if (wr_base) base_q <= wval[RAM_AW-1:0];
            if (wr_mode) mode_q <= wval[1:0];
            if (wr_ictl) ictl_q <= wval[0];

            if (push || xfer_in)  wpos_q <= step(wpos_q, size_q);
            if (pop || xfer_out)  rpos_q <= step(rpos_q, size_q);

            if (push || xfer_in)                cnt_q <= cnt_q + 1'b1;
            else if (xfer_out)                  cnt_q <= cnt_q - 1'b1;
            else if (pop && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;

            if (set_ev)      istat_q <= 1'b1;
            else if (clr_ev) istat_q <= 1'b0;
        end
    end

    // R5
    off_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CH_OFF) |-> !gnt);

    // R6
    recv_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_in |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R7
    drained_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == CH_DRAINED) |-> !gnt);

    // R7
    send_last_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_out && cnt_q == CNT_W'(1)) |=> (istat_q && st_q == CH_DRAINED));
endmodule

// File: rtl/quad_fifo_dma.sv
`timescale 1ns/1ps
module quad_fifo_dma import qfd_pkg::*; #(
    parameter int NCH    = 4,
    parameter int RAM_AW = 10,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_req,
    input  logic             cpu_wr,
    input  logic [17:0]      cpu_addr,
    input  logic [31:0]      cpu_wdata,
    output logic [31:0]      cpu_rdata,
    input  logic [NCH-1:0]   dev_drq,
    output logic [NCH-1:0]   dev_rd,
    input  logic [NCH*8-1:0] dev_rdata,
    output logic [NCH-1:0]   dev_wr,
    output logic [7:0]       dev_wdata,
    output logic             irq
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [CH_W-1:0]   sel;
    logic [7:0]        off;
    logic              hit, wr_hit, rd_hit, data_acc;
    logic              unused_addr;

    logic [RAM_AW-1:0] ch_waddr [NCH];
    logic [RAM_AW-1:0] ch_raddr [NCH];
    logic [RAM_AW-1:0] ch_size  [NCH];
    logic [RAM_AW-1:0] ch_base  [NCH];
    logic [1:0]        ch_mode  [NCH];
    logic [CNT_W-1:0]  ch_cnt   [NCH];
    logic [NCH-1:0]    ch_ictl, ch_istat, ch_want, ch_send;

    logic [NCH-1:0]    arb_gnt, gnt_eff;
    logic [CH_W-1:0]   gidx;
    logic              gany;

    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_wd, ram_rd;
    logic [31:0]       rd_mux;

    assign sel         = cpu_addr[16 +: CH_W];
    assign off         = {cpu_addr[7:2], 2'b00};
    assign hit         = cpu_req && (cpu_addr[15:8] == 8'h00);
    assign wr_hit      = hit && cpu_wr;
    assign rd_hit      = hit && !cpu_wr;
    assign data_acc    = hit && (off == OFF_DATA);
    assign unused_addr = ^cpu_addr[1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic mine;
        assign mine = (sel == CH_W'(i));
        qfd_channel #(.RAM_AW(RAM_AW), .CNT_W(CNT_W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .wr_size (wr_hit && mine && off == OFF_SIZE),
            .wr_base (wr_hit && mine && off == OFF_BASE),
            .wr_mode (wr_hit && mine && off == OFF_MODE),
            .wr_ictl (wr_hit && mine && off == OFF_ICTL),
            .push    (wr_hit && mine && off == OFF_DATA),
            .pop     (rd_hit && mine && off == OFF_DATA),
            .wval    (cpu_wdata),
            .drq     (dev_drq[i]),
            .gnt     (gnt_eff[i]),
            .want    (ch_want[i]),
            .is_send (ch_send[i]),
            .waddr   (ch_waddr[i]),
            .raddr   (ch_raddr[i]),
            .size_q  (ch_size[i]),
            .base_q  (ch_base[i]),
            .mode_q  (ch_mode[i]),
            .ictl_q  (ch_ictl[i]),
            .istat_q (ch_istat[i]),
            .cnt_q   (ch_cnt[i])
        );
    end

    qfd_rr_arbiter #(.N(NCH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (ch_want),
        .advance (!data_acc),
        .gnt     (arb_gnt),
        .gnt_idx (gidx),
        .any     (gany)
    );

    assign gnt_eff = data_acc ? '0 : arb_gnt;
    assign dev_rd  = gnt_eff & ~ch_send;
    assign dev_wr  = gnt_eff & ch_send;

    // single buffer port: data-port access first, then the granted channel
    always_comb begin
        ram_we   = 1'b0;
        ram_addr = '0;
        ram_wd   = '0;
        if (data_acc) begin
            ram_addr = cpu_wr ? ch_waddr[sel] : ch_raddr[sel];
            ram_we   = cpu_wr;
            ram_wd   = cpu_wdata[7:0];
        end else if (gany) begin
            if (ch_send[gidx]) begin
                ram_addr = ch_raddr[gidx];
            end else begin
                ram_addr = ch_waddr[gidx];
                ram_we   = 1'b1;
                ram_wd   = dev_rdata[int'(gidx)*8 +: 8];
            end
        end
    end

    qfd_buffer_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (ram_rd)
    );

    assign dev_wdata = ram_rd;

    always_comb begin
        unique case (off)
            OFF_SIZE:  rd_mux = 32'(ch_size[sel]);
            OFF_BASE:  rd_mux = 32'(ch_base[sel]);
            OFF_MODE:  rd_mux = 32'(ch_mode[sel]);
            OFF_ICTL:  rd_mux = 32'(ch_ictl[sel]);
            OFF_ISTAT: rd_mux = 32'(ch_istat[sel] & ch_ictl[sel]);
            OFF_COUNT: rd_mux = 32'(ch_cnt[sel]);
            OFF_DATA:  rd_mux = {4{ram_rd}};
            default:   rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         cpu_rdata <= 32'h0;
        else if (rd_hit) cpu_rdata <= rd_mux;
    end

    assign irq = |(ch_istat & ch_ictl);

    // R11
    port_access_stall_chk: assert property (@(posedge clk) disable iff (rst)
        data_acc |-> ((dev_rd | dev_wr) == '0));

    // R10
    one_move_per_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_rd | dev_wr));

    // R6
    strobe_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        ((dev_rd | dev_wr) & ~dev_drq) == '0);
endmodule

// File: tb/quad_fifo_dma_bench.sv
`timescale 1ns/1ps
module quad_fifo_dma_bench;
    localparam logic [7:0] O_SIZE = 8'h00, O_BASE = 8'h04, O_MODE = 8'h0C,
                           O_ICTL = 8'h18, O_STAT = 8'h1C, O_CNT = 8'h30, O_DATA = 8'h34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [17:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic [3:0]  dev_drq = '0;
    logic [3:0]  dev_rd, dev_wr;
    logic [31:0] dev_rdata;
    logic [7:0]  dev_wdata;
    logic        irq;

    int nchk = 0, nbad = 0, cyc = 0;
    int rd_seen [4];
    logic [7:0] src_base [4];
    logic [7:0] out_log [4][16];
    int out_n [4];
    int seq [64];
    int seq_n = 0;

    always #2.5 clk = ~clk;

    quad_fifo_dma u_quad_fifo_dma (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dev_drq(dev_drq), .dev_rd(dev_rd),
        .dev_rdata(dev_rdata), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .irq(irq)
    );

    // device model: receive byte = base + number of bytes already taken
    always_comb begin
        for (int i = 0; i < 4; i++) dev_rdata[i*8 +: 8] = src_base[i] + 8'(rd_seen[i]);
    end

    // strobe recorder; inputs only change at negedge, outputs settle before this edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        for (int i = 0; i < 4; i++) begin
            if (dev_rd[i] || dev_wr[i]) begin
                if (seq_n < 64) seq[seq_n] = i;
                seq_n = seq_n + 1;
            end
            if (dev_rd[i]) rd_seen[i] = rd_seen[i] + 1;
            if (dev_wr[i]) begin
                if (out_n[i] < 16) out_log[i][out_n[i]] = dev_wdata;
                out_n[i] = out_n[i] + 1;
            end
        end
        if (cyc == 100000) begin
            nbad = nbad + 1;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    function automatic logic [17:0] adr(input int ch, input logic [7:0] o);
        return {ch[1:0], 8'h00, o};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nbad = nbad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input int ch, input logic [7:0] o, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = adr(ch, o); cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic reg_rd(input int ch, input logic [7:0] o, output logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = adr(ch, o);
        @(negedge clk);
        d = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic drq_cycles(input logic [3:0] m, input int n);
        @(negedge clk);
        dev_drq = m;
        repeat (n) @(negedge clk);
        dev_drq = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 irq", 32'(irq), 0);
        for (int c = 0; c < 4; c++) begin
            reg_rd(c, O_MODE, v); check("R1 mode", v, 0);
            reg_rd(c, O_CNT, v);  check("R1 count", v, 0);
        end
        reg_rd(2, O_SIZE, v); check("R1 size", v, 0);
        reg_rd(1, O_BASE, v); check("R1 base", v, 0);
    endtask

    task automatic t_port_loop;
        logic [31:0] v;
        logic [7:0] exp_b [5];
        exp_b[0] = 8'h55; exp_b[1] = 8'h22; exp_b[2] = 8'h33; exp_b[3] = 8'h44; exp_b[4] = 8'h55;
        reg_wr(1, O_BASE, 32'h100);
        reg_wr(1, O_SIZE, 32'h3);
        reg_rd(1, O_BASE, v); check("R2 base readback", v, 32'h100);
        reg_rd(0, O_BASE, v); check("R2 other channel base", v, 0);
        for (int k = 1; k <= 5; k++) reg_wr(1, O_DATA, 32'(k * 8'h11));
        reg_rd(1, O_CNT, v); check("R3 count after pushes", v, 5);
        for (int k = 0; k < 5; k++) begin
            reg_rd(1, O_DATA, v); check("R3/R4 pop lanes with wrap", v, {4{exp_b[k]}});
            reg_rd(1, O_CNT, v);  check("R4 count after pop", v, 32'(4 - k));
        end
    endtask

    task automatic t_receive;
        logic [31:0] v;
        src_base[2] = 8'hA0;
        reg_wr(2, O_BASE, 32'h200);
        reg_wr(2, O_SIZE, 32'h7);
        reg_wr(2, O_ICTL, 32'h1);
        reg_wr(2, O_MODE, 32'h1);
        drq_cycles(4'b0100, 3);
        check("R6 device reads", 32'(rd_seen[2]), 3);
        reg_rd(2, O_CNT, v);  check("R6 count", v, 3);
        reg_rd(2, O_STAT, v); check("R6 status", v, 1);
        check("R9 irq set", 32'(irq), 1);
        reg_wr(2, O_ICTL, 32'h1);
        reg_rd(2, O_STAT, v); check("R8 control write clears", v, 0);
        check("R9 irq cleared", 32'(irq), 0);
        reg_rd(2, O_CNT, v);  check("R8 count kept", v, 3);
        drq_cycles(4'b0100, 2);
        for (int k = 0; k < 5; k++) begin
            reg_rd(2, O_DATA, v); check("R6 stored byte", v, {4{8'(8'hA0 + k)}});
            if (k == 3) begin
                reg_rd(2, O_STAT, v); check("R4 status holds at count 1", v, 1);
            end
        end
        reg_rd(2, O_STAT, v); check("R4 status cleared on empty", v, 0);
        check("R9 irq after drain", 32'(irq), 0);
        reg_wr(2, O_ICTL, 32'h0);
        drq_cycles(4'b0100, 1);
        reg_rd(2, O_CNT, v);  check("R8 masked count", v, 1);
        reg_rd(2, O_STAT, v); check("R8 masked status reads 0", v, 0);
        check("R9 masked irq", 32'(irq), 0);
        reg_rd(2, O_DATA, v); check("R6 masked byte", v, {4{8'hA5}});
    endtask

    task automatic t_send;
        logic [31:0] v;
        reg_wr(3, O_BASE, 32'h300);
        reg_wr(3, O_SIZE, 32'h3);
        reg_wr(3, O_DATA, 32'h31);
        reg_wr(3, O_DATA, 32'h32);
        reg_wr(3, O_DATA, 32'h33);
        reg_wr(3, O_ICTL, 32'h1);
        reg_wr(3, O_MODE, 32'h3);
        drq_cycles(4'b1000, 5);
        check("R7 bytes sent", 32'(out_n[3]), 3);
        check("R7 byte 0", 32'(out_log[3][0]), 32'h31);
        check("R7 byte 1", 32'(out_log[3][1]), 32'h32);
        check("R7 byte 2", 32'(out_log[3][2]), 32'h33);
        reg_rd(3, O_CNT, v);  check("R7 count empty", v, 0);
        reg_rd(3, O_STAT, v); check("R7 status on last", v, 1);
        check("R9 irq on send done", 32'(irq), 1);
        @(negedge clk);
        dev_drq = 4'b1000;
        reg_wr(3, O_DATA, 32'h34);
        repeat (3) @(negedge clk);
        check("R7 drained stays silent", 32'(out_n[3]), 3);
        reg_rd(3, O_CNT, v); check("R7 drained count", v, 1);
        reg_wr(3, O_MODE, 32'h3);
        repeat (2) @(negedge clk);
        dev_drq = '0;
        check("R7 resumed after mode write", 32'(out_n[3]), 4);
        check("R7 resumed byte", 32'(out_log[3][3]), 32'h34);
        reg_wr(3, O_ICTL, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] v;
        src_base[0] = 8'h50;
        reg_wr(0, O_MODE, 32'h2);
        drq_cycles(4'b0001, 3);
        check("R5 no strobe when disabled", 32'(rd_seen[0] + out_n[0]), 0);
        reg_rd(0, O_CNT, v); check("R5 disabled count", v, 0);
        reg_wr(0, O_CNT, 32'h55);
        reg_wr(0, O_STAT, 32'h1);
        reg_rd(0, O_CNT, v); check("R12 count write ignored", v, 0);
        reg_wr(0, O_ICTL, 32'h1);
        reg_wr(0, O_STAT, 32'h1);
        reg_rd(0, O_STAT, v); check("R12 status write ignored", v, 0);
        reg_wr(0, O_ICTL, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        reg_wr(0, O_BASE, 32'h000);
        reg_wr(0, O_SIZE, 32'hF);
        reg_wr(0, O_MODE, 32'h1);
        @(negedge clk);
        dev_drq = 4'b0001;
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = adr(0, O_DATA); cpu_wdata = 32'h77;
        @(negedge clk);
        cpu_req = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        dev_drq = '0;
        check("R11 strobes around port access", 32'(rd_seen[0]), 2);
        reg_rd(0, O_CNT, v);  check("R11 count once each", v, 3);
        reg_wr(0, O_MODE, 32'h0);
        reg_rd(0, O_DATA, v); check("R11 order 0", v, {4{8'h50}});
        reg_rd(0, O_DATA, v); check("R11 order 1", v, {4{8'h77}});
        reg_rd(0, O_DATA, v); check("R11 order 2", v, {4{8'h51}});
    endtask

    task automatic t_rotate;
        logic [31:0] v;
        src_base[1] = 8'hC0;
        reg_wr(0, O_MODE, 32'h1);
        reg_wr(1, O_MODE, 32'h1);
        @(negedge clk);
        seq_n = 0;
        drq_cycles(4'b0011, 4);
        check("R10 one transfer per clock", 32'(seq_n), 4);
        check("R10 rotate 0-1", 32'(seq[0] != seq[1]), 1);
        check("R10 rotate 1-2", 32'(seq[1] != seq[2]), 1);
        check("R10 rotate 2-3", 32'(seq[2] != seq[3]), 1);
        reg_rd(0, O_CNT, v); check("R10 share ch0", v, 2);
        reg_rd(1, O_CNT, v); check("R10 share ch1", v, 2);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            rd_seen[i] = 0; out_n[i] = 0; src_base[i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_port_loop();
        t_receive();
        t_send();
        t_disabled();
        t_collide();
        t_rotate();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule